// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a parameterizable number of level-sensitive interrupt lines (64 by default) and presents them to one processor through a small word-addressed register bus and a single interrupt output. Every line can also be raised from software: each line owns a software-trigger bit that is ORed with its wire, plus one mask bit. Both kinds of bit are changed only through paired write-one-to-set and write-one-to-clear banks, so software never needs a read-modify-write.

Software services interrupts by reading one event register. The read returns a packed word naming the lowest-numbered line that is pending and unmasked, and in the same clock edge the controller sets that line's mask bit. Software handles the source and then clears the mask to re-arm the line. A global enable gates both the event register and the interrupt output. Each line also has a config word that stores a routing target and a delay-group index for software; the controller only stores and returns these fields.

Top module: `irqController`

## Requirements
- R1: After reset every mask bit is 1, every software-trigger bit is 0, the enable bit is 0, `irqOut` is 0 and an event read returns 0.
- R2: Line n is pending while `hwIrq[n]` is 1 or its software-trigger bit is 1; the raw-state bank (read-only) returns the `hwIrq` levels.
- R3: Writing 1 to a bit of the mask-set bank sets that mask bit; writing 1 to a bit of the mask-clear bank clears it; 0 bits change nothing. Both mask banks read back the current mask bits.
- R4: Writing 1 to a bit of the soft-set bank sets that software-trigger bit; writing 1 to a bit of the soft-clear bank clears it; 0 bits change nothing. Both soft banks read back the current software-trigger bits.
- R5: Line n sits at bit n&31 of word n>>5 of each bank (byte offset 4*(n>>5)). With CFG_BASE = 0x2000 the config words sit at 0x2000 + 4n, followed in this order by the soft-set, soft-clear, mask-set, mask-clear and raw-state banks, each NUM_IRQ/32 words long (0x2100, 0x2108, 0x2110, 0x2118, 0x2120 for 64 lines).
- R6: The event word at 0x0008 carries the die index (DIE_ID, 0 by default) in bits [31:24], the type code 1 (hardware line) in bits [23:16] and the line number in bits [15:0]; it reads as 0 when nothing is pending and unmasked.
- R7: When several lines are pending and unmasked, the lowest-numbered line is reported.
- R8: An event read that reports a line sets that line's mask bit in the same clock edge that latches the read; the line stays masked until the mask-clear bank clears it. Reads have one cycle of latency, so back-to-back event reads return successive candidates.
- R9: Each config word stores a target field in bits [3:0] and a delay-group index in bits [7:5]; all other bits read as 0.
- R10: The control register at 0x0004 holds the enable in bit 0. While enable is 0, event reads return 0 and mask nothing, and `irqOut` stays 0.
- R11: The info register at 0x0000 returns NUM_IRQ in bits [15:0] and the last die index (LAST_DIE, 0 by default) in bits [27:24]; other bits read 0.
- R12: `irqOut` is 1 exactly when enable is 1 and at least one pending line is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address, low two bits ignored |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe; data appears one cycle later |
| busRdData | output | 32 | Registered read data |
| hwIrq | input | NUM_IRQ | Level-sensitive interrupt lines |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench walks every line through trigger, unmask, event read and re-mask, so a wrong word or bit mapping, a wrong event field layout, or an ack that masks the wrong line shows up as a mismatched event word or mask readback. A burst of back-to-back event reads with all lines pending catches a priority encoder that favours high numbers or an auto-mask that lands one cycle late, which would report the same line twice. Reads while disabled catch a design that masks lines it never reported, and write-zero and config-readback sweeps catch banks that overwrite rather than set or clear and config words that keep reserved bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_INFO,
    SEL_CTRL,
    SEL_EVENT,
    SEL_CFG,
    SEL_SOFT,
    SEL_MASK,
    SEL_RAW
  } readSelT;

  // Strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic        softSet;
    logic        softClr;
    logic        maskSet;
    logic        maskClr;
    logic        cfgWr;
    logic        eventRd;
    logic        rdEn;
    readSelT     rdSel;
    logic [15:0] irqIdx;
    logic [15:0] wordIdx;
  } ctrlStrobesT;

  localparam logic [7:0] EVENT_TYPE_HW = 8'd1;

endpackage

// File: rtl/irqcCtrl.sv
module irqcCtrl
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int ADDR_W   = 16,
  parameter int CFG_BASE = 32'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              ctrlBit,
  input  logic              busRdEn,
  output logic              enable,
  output ctrlStrobesT       strb
);

  localparam int WORDS      = NUM_IRQ / 32;
  localparam int BANK_BYTES = 4 * WORDS;
  localparam int SSET_BASE  = CFG_BASE + 4 * NUM_IRQ;
  localparam int SCLR_BASE  = SSET_BASE + BANK_BYTES;
  localparam int MSET_BASE  = SCLR_BASE + BANK_BYTES;
  localparam int MCLR_BASE  = MSET_BASE + BANK_BYTES;
  localparam int RAW_BASE   = MCLR_BASE + BANK_BYTES;
  localparam logic [31:0] INFO_ADDR  = 32'h0;
  localparam logic [31:0] CTRL_ADDR  = 32'h4;
  localparam logic [31:0] EVENT_ADDR = 32'h8;

  logic [31:0] aw;
  assign aw = 32'(busAddr) & ~32'd3;

  function automatic logic inWin(logic [31:0] a, int base, int len);
    return (a >= 32'(base)) && (a < 32'(base + len));
  endfunction

  logic hitCfg, hitSSet, hitSClr, hitMSet, hitMClr, hitRaw;
  logic hitInfo, hitCtrl, hitEvent;
  logic [31:0] bankBase;

  always_comb begin
    hitInfo  = (aw == INFO_ADDR);
    hitCtrl  = (aw == CTRL_ADDR);
    hitEvent = (aw == EVENT_ADDR);
    hitCfg   = inWin(aw, CFG_BASE, 4 * NUM_IRQ);
    hitSSet  = inWin(aw, SSET_BASE, BANK_BYTES);
    hitSClr  = inWin(aw, SCLR_BASE, BANK_BYTES);
    hitMSet  = inWin(aw, MSET_BASE, BANK_BYTES);
    hitMClr  = inWin(aw, MCLR_BASE, BANK_BYTES);
    hitRaw   = inWin(aw, RAW_BASE, BANK_BYTES);

    bankBase = 32'(SSET_BASE);
    if (hitSClr) bankBase = 32'(SCLR_BASE);
    if (hitMSet) bankBase = 32'(MSET_BASE);
    if (hitMClr) bankBase = 32'(MCLR_BASE);
    if (hitRaw)  bankBase = 32'(RAW_BASE);
  end

  always_comb begin
    strb         = '0;
    strb.irqIdx  = 16'((aw - 32'(CFG_BASE)) >> 2);
    strb.wordIdx = 16'((aw - bankBase) >> 2);
    strb.softSet = busWrEn & hitSSet;
    strb.softClr = busWrEn & hitSClr;
    strb.maskSet = busWrEn & hitMSet;
    strb.maskClr = busWrEn & hitMClr;
    strb.cfgWr   = busWrEn & hitCfg;
    strb.eventRd = busRdEn & hitEvent;
    strb.rdEn    = busRdEn;
    if (hitInfo)                 strb.rdSel = SEL_INFO;
    else if (hitCtrl)            strb.rdSel = SEL_CTRL;
    else if (hitEvent)           strb.rdSel = SEL_EVENT;
    else if (hitCfg)             strb.rdSel = SEL_CFG;
    else if (hitSSet | hitSClr)  strb.rdSel = SEL_SOFT;
    else if (hitMSet | hitMClr)  strb.rdSel = SEL_MASK;
    else if (hitRaw)             strb.rdSel = SEL_RAW;
    else                         strb.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  enable <= 1'b0;
    else if (busWrEn & hitCtrl) enable <= ctrlBit;
  end

  // At most one write target per cycle (R3, R4)
  p_single_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.softSet, strb.softClr, strb.maskSet, strb.maskClr,
              strb.cfgWr, busWrEn & hitCtrl}));

  // Event strobe only from a read of the event address (R8)
  p_event_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.eventRd |-> (busRdEn && strb.rdSel == SEL_EVENT));

endmodule

// File: rtl/irqcDatapath.sv
module irqcDatapath
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int DIE_ID   = 0,
  parameter int LAST_DIE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobesT        strb,
  input  logic               enable,
  input  logic [31:0]        wrData,
  input  logic [NUM_IRQ-1:0] hwIrq,
  output logic [31:0]        rdData,
  output logic               irqOut
);

  localparam int WORDS   = NUM_IRQ / 32;
  localparam int CFG_W   = 7;

  logic [NUM_IRQ-1:0] maskQ, softQ, maskN, softN;
  logic [NUM_IRQ-1:0] pending, active;
  logic [NUM_IRQ*CFG_W-1:0] cfgVec;
  logic               found, eventValid, ackNow;
  logic [15:0]        winIdx;
  logic [31:0]        eventWord, infoWord, rdMux;

  assign pending = hwIrq | softQ;
  assign active  = pending & ~maskQ;

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (active[i]) begin
        found  = 1'b1;
        winIdx = 16'(i);
      end
    end
  end

  assign eventValid = enable & found;
  assign eventWord  = eventValid ? {8'(DIE_ID), EVENT_TYPE_HW, winIdx} : 32'd0;
  assign ackNow     = strb.eventRd & eventValid;
  assign irqOut     = enable & (|active);
  assign infoWord   = {4'd0, 4'(LAST_DIE), 8'd0, 16'(NUM_IRQ)};

  always_comb begin
    maskN = maskQ;
    softN = softQ;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(strb.wordIdx) == w) begin
        if (strb.maskSet) maskN[w*32 +: 32] = maskQ[w*32 +: 32] | wrData;
        if (strb.maskClr) maskN[w*32 +: 32] = maskQ[w*32 +: 32] & ~wrData;
        if (strb.softSet) softN[w*32 +: 32] = softQ[w*32 +: 32] | wrData;
        if (strb.softClr) softN[w*32 +: 32] = softQ[w*32 +: 32] & ~wrData;
      end
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (ackNow && int'(winIdx) == i) maskN[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      softQ <= '0;
    end else begin
      maskQ <= maskN;
      softQ <= softN;
    end
  end

  // One config register per line: target [3:0], delay group [7:5].
  for (genvar g = 0; g < NUM_IRQ; g++) begin : gCfg
    logic [CFG_W-1:0] cfgReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgReg <= '0;
      else if (strb.cfgWr && int'(strb.irqIdx) == g)
        cfgReg <= {wrData[7:5], wrData[3:0]};
    end
    assign cfgVec[g*CFG_W +: CFG_W] = cfgReg;
  end

  always_comb begin
    rdMux = '0;
    unique case (strb.rdSel)
      SEL_INFO:  rdMux = infoWord;
      SEL_CTRL:  rdMux = {31'd0, enable};
      SEL_EVENT: rdMux = eventWord;
      SEL_CFG: begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (int'(strb.irqIdx) == i)
            rdMux = {24'd0, cfgVec[i*CFG_W+4 +: 3], 1'b0, cfgVec[i*CFG_W +: 4]};
      end
      SEL_SOFT: begin
        for (int w = 0; w < WORDS; w++)
          if (int'(strb.wordIdx) == w) rdMux = softQ[w*32 +: 32];
      end
      SEL_MASK: begin
        for (int w = 0; w < WORDS; w++)
          if (int'(strb.wordIdx) == w) rdMux = maskQ[w*32 +: 32];
      end
      SEL_RAW: begin
        for (int w = 0; w < WORDS; w++)
          if (int'(strb.wordIdx) == w) rdMux = hwIrq[w*32 +: 32];
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end

  // ---- checks: one-cycle history of the strobes ----
  logic        prevAck, prevMaskSet, prevSoftClr, prevDisRd;
  logic [15:0] prevWin, prevWord;
  logic [31:0] prevData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAck     <= 1'b0;
      prevMaskSet <= 1'b0;
      prevSoftClr <= 1'b0;
      prevDisRd   <= 1'b0;
      prevWin     <= '0;
      prevWord    <= '0;
      prevData    <= '0;
    end else begin
      prevAck     <= ackNow;
      prevMaskSet <= strb.maskSet;
      prevSoftClr <= strb.softClr;
      prevDisRd   <= strb.eventRd & ~enable;
      prevWin     <= winIdx;
      prevWord    <= strb.wordIdx;
      prevData    <= wrData;
    end
  end

  p_ack_masks_r8: assert property (@(posedge clk) disable iff (!rstN)
    prevAck |-> maskQ[prevWin[$clog2(NUM_IRQ)-1:0]]);

  p_ack_reports_r6: assert property (@(posedge clk) disable iff (!rstN)
    prevAck |-> (rdData[23:16] == EVENT_TYPE_HW && rdData[15:0] == prevWin));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    found |-> ((active & ((NUM_IRQ'(1) << winIdx) - NUM_IRQ'(1))) == '0));

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    prevMaskSet |-> ((maskQ[prevWord[$clog2(WORDS+1)-1:0]*32 +: 32] & prevData) == prevData));

  p_soft_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    prevSoftClr |-> ((softQ[prevWord[$clog2(WORDS+1)-1:0]*32 +: 32] & prevData) == 32'd0));

  p_disabled_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    prevDisRd |-> (rdData == 32'd0));

endmodule

// File: rtl/irqController.sv
module irqController
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int ADDR_W   = 16,
  parameter int CFG_BASE = 32'h2000,
  parameter int DIE_ID   = 0,
  parameter int LAST_DIE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busRdEn,
  output logic [31:0]        busRdData,
  input  logic [NUM_IRQ-1:0] hwIrq,
  output logic               irqOut
);

  ctrlStrobesT strb;
  logic        enable;

  irqcCtrl #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W),
    .CFG_BASE(CFG_BASE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .ctrlBit(busWrData[0]),
    .busRdEn(busRdEn),
    .enable (enable),
    .strb   (strb)
  );

  irqcDatapath #(
    .NUM_IRQ (NUM_IRQ),
    .DIE_ID  (DIE_ID),
    .LAST_DIE(LAST_DIE)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .enable(enable),
    .wrData(busWrData),
    .hwIrq (hwIrq),
    .rdData(busRdData),
    .irqOut(irqOut)
  );

  // Output stays low while disabled (R12)
  p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !irqOut);

endmodule

// File: tb/irqController_test.sv
module irqController_test;

  localparam int N = 64;
  localparam logic [15:0] A_INFO = 16'h0000, A_CTRL = 16'h0004, A_EVT = 16'h0008;
  localparam logic [15:0] A_CFG  = 16'h2000, A_SSET = 16'h2100, A_SCLR = 16'h2108;
  localparam logic [15:0] A_MSET = 16'h2110, A_MCLR = 16'h2118, A_RAW = 16'h2120;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [N-1:0] hwIrq = '0;
  logic        irqOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqController uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .hwIrq(hwIrq), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hwIrq = '0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] evt(int n);
    return {8'h00, 8'h01, 16'(n)};
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 irqOut", 32'(irqOut), 32'd0);
    for (int w = 0; w < 2; w++) begin
      rd(A_MSET + 16'(4*w), d); check("R1 masks", d, 32'hFFFF_FFFF);
      rd(A_SSET + 16'(4*w), d); check("R1 soft", d, 32'd0);
    end
    rd(A_CTRL, d); check("R1 enable", d, 32'd0);
    rd(A_EVT, d);  check("R1 event", d, 32'd0);

    // R11: info
    rd(A_INFO, d); check("R11 info", d, 32'h0000_0040);

    // R10: disabled controller reports nothing and masks nothing
    wr(A_SSET, 32'h20); wr(A_MCLR, 32'h20);
    check("R10 irqOut off", 32'(irqOut), 32'd0);
    rd(A_EVT, d); check("R10 event off", d, 32'd0);
    rd(A_MCLR, d); check("R10 no auto-mask", d, 32'hFFFF_FFDF);
    wr(A_CTRL, 32'h1);
    check("R12 irqOut on", 32'(irqOut), 32'd1);
    rd(A_CTRL, d); check("R10 enable readback", d, 32'd1);
    wr(A_MSET, 32'h20);
    check("R12 irqOut masked", 32'(irqOut), 32'd0);
    wr(A_SCLR, 32'h20);

    // R3/R4: zero writes change nothing
    wr(A_MCLR, 32'd0); wr(A_SSET, 32'd0);
    rd(A_MSET, d);  check("R3 write zero", d, 32'hFFFF_FFFF);
    rd(A_SCLR, d);  check("R4 write zero", d, 32'd0);

    // R4/R5/R6/R8: every line through software trigger
    for (int n = 0; n < N; n++) begin
      logic [15:0] wo;
      logic [31:0] bitv;
      wo = 16'(4 * (n >> 5));
      bitv = 32'd1 << (n & 31);
      wr(A_SSET + wo, bitv);
      rd(A_SSET + wo, d); check("R4 soft set", d, bitv);
      wr(A_MCLR + wo, bitv);
      check("R12 irqOut line", 32'(irqOut), 32'd1);
      rd(A_EVT, d); check("R6 event word", d, evt(n));
      check("R8 irqOut after ack", 32'(irqOut), 32'd0);
      rd(A_MSET + wo, d); check("R8 auto-mask", d, 32'hFFFF_FFFF);
      rd(A_EVT, d); check("R8 stays masked", d, 32'd0);
      wr(A_SCLR + wo, bitv);
      rd(A_SCLR + wo, d); check("R4 soft clear", d, 32'd0);
    end

    // R2: every line through the hardware wire
    for (int n = 0; n < N; n++) begin
      logic [15:0] wo;
      logic [31:0] bitv;
      wo = 16'(4 * (n >> 5));
      bitv = 32'd1 << (n & 31);
      @(negedge clk); hwIrq = N'(1) << n;
      rd(A_RAW + wo, d); check("R2 raw state", d, bitv);
      wr(A_MCLR + wo, bitv);
      rd(A_EVT, d); check("R2 hw event", d, evt(n));
      @(negedge clk); hwIrq = '0;
    end

    // R2: soft and wire together on one line, still one event
    @(negedge clk); hwIrq = N'(1) << 9;
    wr(A_SSET, 32'h200); wr(A_MCLR, 32'h200);
    rd(A_EVT, d); check("R2 or of sources", d, evt(9));
    @(negedge clk); hwIrq = '0;
    wr(A_SCLR, 32'h200);

    // R7/R8: sparse priority, back-to-back
    wr(A_SSET, 32'h80); wr(A_SSET + 4, 32'h102);
    wr(A_MCLR, 32'hFFFF_FFFF); wr(A_MCLR + 4, 32'hFFFF_FFFF);
    @(negedge clk); busAddr = A_EVT; busRdEn = 1'b1;
    @(negedge clk); check("R7 first", busRdData, evt(7));
    @(negedge clk); check("R7 second", busRdData, evt(33));
    @(negedge clk); check("R7 third", busRdData, evt(40));
    @(negedge clk); check("R8 drained", busRdData, 32'd0);
    busRdEn = 1'b0;
    wr(A_SCLR, 32'hFFFF_FFFF); wr(A_SCLR + 4, 32'hFFFF_FFFF);

    // R7/R8: all lines pending, burst of back-to-back reads
    wr(A_SSET, 32'hFFFF_FFFF); wr(A_SSET + 4, 32'hFFFF_FFFF);
    wr(A_MCLR, 32'hFFFF_FFFF); wr(A_MCLR + 4, 32'hFFFF_FFFF);
    @(negedge clk); busAddr = A_EVT; busRdEn = 1'b1;
    for (int k = 0; k <= N; k++) begin
      @(negedge clk);
      check("R7 burst order", busRdData, (k < N) ? evt(k) : 32'd0);
    end
    busRdEn = 1'b0;
    // R8: unmask one line again re-arms it
    wr(A_MCLR + 4, 32'h0000_0010);
    rd(A_EVT, d); check("R8 re-arm", d, evt(36));

    // R9: config word storage
    doReset();
    for (int n = 0; n < N; n++)
      wr(A_CFG + 16'(4*n), 32'hFFFF_FF00 | 32'((n * 29) & 8'hFF));
    for (int n = 0; n < N; n++) begin
      rd(A_CFG + 16'(4*n), d);
      check("R9 config", d, 32'((n * 29) & 8'hEF));
    end
    rd(A_MSET, d); check("R5 config does not touch masks", d, 32'hFFFF_FFFF);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule